// File: doc/BRIEF.md
# I2S slave transceiver

This block is the serial end of an audio link in which an external master owns the bit clock and the frame sync. Both of those inputs are oversampled on the system clock through two-flop synchronizers. Every shift and capture is then driven by edges found on the synchronized copies, so the whole block runs in one clock domain.

Software, or a DMA engine, writes a word into the transmit holding buffer and reads the word collected in the receive holding buffer. A request flag for each buffer tells it when to do so. A frame boundary moves the next transmit word into the output shifter and hands the finished receive word to the receive buffer. If no transmit word is waiting when the frame begins, the block sends zeros and raises a sticky error flag. Bit order is chosen per access: a swapped write sends the word LSB-first, and a swapped read view returns the received word LSB-first.

Top module: `i2s_slave_xcvr`

## Requirements
- R1: After reset `tx_req_o`=1, `rx_req_o`=0, `err_o`=0 and `sd_o`=0.
- R2: `sd_o` carries the new bit no later than 3 system clock cycles after the bit clock falls. The bit clock may therefore run at up to one sixth of the system clock, with each half period at least 3 cycles long.
- R3: A frame starts at a bit-clock falling edge where `fs_i` is 1 and was 0 at the previous falling edge. The frame start moves the transmit buffer into the shifter and empties the buffer, so `tx_req_o` returns to 1.
- R4: The shifter drives its most significant bit on `sd_o` first and moves one bit on at each later falling edge, which gives MSB-first output of the stored value.
- R5: A write with `tx_swap_i`=1 stores `tx_data_i` bit-reversed, so that word is sent LSB-first.
- R6: `sd_i` is sampled at each bit-clock rising edge. The first bit sampled after a frame start becomes bit WORD_W-1 of `rx_data_o`. `rx_data_swap_o` is the same word bit-reversed.
- R7: At a frame start the receive word is moved to the receive buffer and `rx_req_o` is set, but only if at least WORD_W bits arrived since the previous frame start. A pulse on `rx_re_i` clears `rx_req_o`.
- R8: When a frame starts with the transmit buffer empty, the frame sends all zeros and `err_o` becomes 1 and stays 1.
- R9: A pulse on `err_clr_i` clears `err_o`. A new underrun in the same cycle takes priority over the clear.
- R10: A pulse on `tx_we_i` fills the transmit buffer, so `tx_req_o` becomes 0. A write in the same cycle as a frame start goes into the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | External bit clock |
| fs_i | input | 1 | External frame sync |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| tx_data_i | input | WORD_W | Transmit word |
| tx_we_i | input | 1 | Transmit buffer write strobe |
| tx_swap_i | input | 1 | Store the written word bit-reversed |
| tx_req_o | output | 1 | Transmit buffer empty |
| rx_data_o | output | WORD_W | Receive word, MSB-first view |
| rx_data_swap_o | output | WORD_W | Receive word, bit-reversed view |
| rx_re_i | input | 1 | Receive buffer read strobe |
| rx_req_o | output | 1 | Receive buffer full |
| err_o | output | 1 | Sticky transmit underrun flag |
| err_clr_i | input | 1 | Clear the underrun flag |

## Verification
The bench builds the block with WORD_W=8. This makes it practical to send every one of the 256 transmit values as its own frame, together with a matching sweep of receive words. Swapped and plain writes alternate from frame to frame, and every seventh frame is left without a transmit word to force an underrun. The external bit clock runs at the divide-by-6 limit, and each output bit is sampled in the last cycle before the master's rising edge. This checks the latency bound on every bit rather than at a relaxed rate.

// File: rtl/i2s_slv_pkg.sv
package i2s_slv_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/i2s_slv_sync.sv
module i2s_slv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  output logic lvl_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], a_i};
  end

  assign lvl_o = q[STAGES-1];
endmodule

// File: rtl/i2s_slv_tx.sv
module i2s_slv_tx #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  input  logic         we_i,
  input  logic         swap_i,
  input  logic         err_clr_i,
  output logic         sd_o,
  output logic         req_o,
  output logic         err_o
);
  logic [W-1:0] buf_q, sh_q, data_rev, wr_val;
  logic         full_q, err_q;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign data_rev[i] = data_i[W-1-i];
  end

  assign wr_val = swap_i ? data_rev : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (load_i)       sh_q <= full_q ? buf_q : '0;
      else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
      if (we_i) begin
        buf_q  <= wr_val;
        full_q <= 1'b1;
      end else if (load_i) begin
        full_q <= 1'b0;
      end
      // a fresh underrun outranks a clear
      if (load_i && !full_q) err_q <= 1'b1;
      else if (err_clr_i)    err_q <= 1'b0;
    end
  end

  assign sd_o  = sh_q[W-1];
  assign req_o = ~full_q;
  assign err_o = err_q;

  assert_underrun_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !full_q) |=> err_q);
  assert_underrun_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !full_q) |=> (sh_q == '0));
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr_i) |=> err_q);
  assert_load_empties_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && full_q && !we_i) |=> !full_q);
  assert_load_msb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && full_q) |=> (sd_o == $past(buf_q[W-1])));
  assert_write_fills_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !req_o);
endmodule

// File: rtl/i2s_slv_rx.sv
module i2s_slv_rx #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_i,
  input  logic         deliver_i,
  input  logic         sd_i,
  input  logic         re_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] data_swap_o,
  output logic         req_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q, buf_q;
  logic [CW-1:0] cnt_q;
  logic          full_q, word_done;

  assign word_done = (cnt_q == CW'(W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      buf_q  <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (sample_i) sh_q <= {sh_q[W-2:0], sd_i};
      if (deliver_i)                    cnt_q <= '0;
      else if (sample_i && !word_done)  cnt_q <= cnt_q + 1'b1;
      if (deliver_i && word_done) begin
        buf_q  <= sh_q;
        full_q <= 1'b1;
      end else if (re_i) begin
        full_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign data_swap_o[i] = buf_q[W-1-i];
  end

  assign data_o = buf_q;
  assign req_o  = full_q;

  assert_no_short_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_i && !word_done) |=> $stable(buf_q));
  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !(deliver_i && word_done)) |=> !req_o);
  assert_deliver_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_i && word_done) |=> req_o);
endmodule

// File: rtl/i2s_slave_xcvr.sv
module i2s_slave_xcvr
  import i2s_slv_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              fs_i,
  input  logic              sd_i,
  output logic              sd_o,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_we_i,
  input  logic              tx_swap_i,
  output logic              tx_req_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic [WORD_W-1:0] rx_data_swap_o,
  input  logic              rx_re_i,
  output logic              rx_req_o,
  output logic              err_o,
  input  logic              err_clr_i
);
  logic  sck_s, fs_s, sck_d, fs_at_fall, frame_start;
  edge_t sck_e;

  i2s_slv_sync #(.STAGES(SYNC_DEPTH)) i_sync_sck (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(sck_i), .lvl_o(sck_s));
  i2s_slv_sync #(.STAGES(SYNC_DEPTH)) i_sync_fs (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(fs_i), .lvl_o(fs_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d      <= 1'b0;
      fs_at_fall <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (sck_e.fall) fs_at_fall <= fs_s;
    end
  end

  assign sck_e.rise  = sck_s & ~sck_d;
  assign sck_e.fall  = ~sck_s & sck_d;
  assign frame_start = sck_e.fall & fs_s & ~fs_at_fall;

  i2s_slv_tx #(.W(WORD_W)) i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(frame_start), .shift_i(sck_e.fall & ~frame_start),
    .data_i(tx_data_i), .we_i(tx_we_i), .swap_i(tx_swap_i),
    .err_clr_i(err_clr_i),
    .sd_o(sd_o), .req_o(tx_req_o), .err_o(err_o));

  i2s_slv_rx #(.W(WORD_W)) i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sample_i(sck_e.rise), .deliver_i(frame_start), .sd_i(sd_i),
    .re_i(rx_re_i),
    .data_o(rx_data_o), .data_swap_o(rx_data_swap_o), .req_o(rx_req_o));

  assert_start_needs_fs_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start |=> fs_at_fall);
endmodule

// File: tb/test_i2s_slave_xcvr.sv
module test_i2s_slave_xcvr;
  localparam int W    = 8;
  localparam int HALF = 3;
  localparam int NF   = 256;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic rst_ni, sck_i, fs_i, sd_i, sd_o;
  logic [W-1:0] tx_data_i, rx_data_o, rx_data_swap_o;
  logic tx_we_i, tx_swap_i, tx_req_o, rx_re_i, rx_req_o, err_o, err_clr_i;

  i2s_slave_xcvr #(.WORD_W(W)) i_i2s_slave_xcvr (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rx_prev;
    rst_ni = 0; sck_i = 1; fs_i = 0; sd_i = 0;
    tx_data_i = '0; tx_we_i = 0; tx_swap_i = 0; rx_re_i = 0; err_clr_i = 0;
    rx_prev = '0;
    cyc(3);
    rst_ni = 1;
    cyc(4);
    chk("R1 tx_req", tx_req_o, 1);
    chk("R1 rx_req", rx_req_o, 0);
    chk("R1 err",    err_o,    0);
    chk("R1 sd_o",   sd_o,     0);

    for (int k = 0; k <= NF; k++) begin
      logic [W-1:0] txw, rxw, got, expw;
      bit und, sw;
      txw = W'(k);
      rxw = W'(k * 37 + 11);
      und = (k % 7 == 3) || (k == NF);
      sw  = (k % 2 == 1);
      if (!und) begin
        tx_data_i = txw; tx_swap_i = sw; tx_we_i = 1;
        cyc(1);
        tx_we_i = 0;
        chk("R10 write fills buffer", tx_req_o, 0);
      end
      got = '0;
      for (int b = 0; b < W; b++) begin
        sck_i = 0; fs_i = (b == 0); sd_i = rxw[W-1-b];
        cyc(HALF);
        got[W-1-b] = sd_o;  // last cycle before master's rising edge (R2)
        sck_i = 1;
        cyc(HALF);
      end
      if (k < NF) begin
        expw = und ? '0 : (sw ? rev(txw) : txw);
        if (und)     chk("R8 underrun sends zeros", got, expw);
        else if (sw) chk("R5/R2 swapped word LSB-first", got, expw);
        else         chk("R4/R2 word MSB-first", got, expw);
        chk("R3 frame start empties buffer", tx_req_o, 1);
        if (und) begin
          chk("R8 underrun flag", err_o, 1);
          err_clr_i = 1; cyc(1); err_clr_i = 0;
          chk("R9 clear flag", err_o, 0);
        end else begin
          chk("R8 no underrun flag", err_o, 0);
        end
      end
      if (k == 0) begin
        chk("R7 no delivery before full word", rx_req_o, 0);
      end else begin
        chk("R7 rx request", rx_req_o, 1);
        chk("R6 rx word", rx_data_o, rx_prev);
        chk("R6 rx swapped view", rx_data_swap_o, rev(rx_prev));
        rx_re_i = 1; cyc(1); rx_re_i = 0;
        chk("R7 read clears request", rx_req_o, 0);
      end
      rx_prev = rxw;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule